// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides, at each instruction boundary of a small 4-bit CPU core, whether an interrupt is taken. When one is, it drives the short series of bus steps that save the machine state and then steer the program counter to a handler. It weighs a non-maskable request, a set of maskable hardware requests and the software-interrupt instruction. The return instruction runs the reverse series, which restores the saved state.

Two stacks hold the saved state. The 16-bit return address goes to the address stack through its own pointer, and the 4-bit flag register goes to the data stack through a second pointer. Both pointers are 8 bits wide: a save writes one entry below the pointer and moves the pointer down, and a restore reads at the pointer and moves it up. A request is held off by one instruction in two cases: when the instruction that just finished set the interrupt-enable flag, and when it was an extension-register load. While a sequence runs, the block raises a busy line so that the core stalls.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable request is taken at a boundary whatever the interrupt-enable flag (flag bit 3) holds, and it wins over every maskable request that is active in the same cycle. Its handler address is 0x0002.
- R2: A maskable request is taken only when flag bit 3 is 1. When several are active, the lowest index wins, and only that index is acknowledged.
- R3: At a boundary that follows an instruction which set the enable flag, no maskable request is taken. The same request is taken at the next boundary.
- R4: At a boundary that follows an extension-register load, no hardware request is taken, not even the non-maskable one. The request is taken at the next boundary.
- R5: Entry takes four cycles in this order: one dummy fetch cycle, a write of the return address to address-stack slot SP1-1, a write of the flags to data-stack slot SP2-1, and then the vector load. Each pointer moves down by one after its write.
- R6: A hardware entry saves the address of the current boundary instruction as the return address. A software interrupt saves that address plus one.
- R7: A software interrupt jumps to 0x0100 plus its 6-bit field. Maskable source i jumps to 0x0006 + 2*i, which comes from a parameter table.
- R8: The flag register as it was at acceptance is the value pushed. In the vector-load cycle the block writes the flags back with bit 3 cleared.
- R9: Return takes three cycles: a dummy cycle, then the flags are loaded from data-stack slot SP2 and SP2 moves up by one, then the PC is loaded from address-stack slot SP1 and SP1 moves up by one.
- R10: After reset the block is idle, no write, load or acknowledge is active, and both pointers hold 0, so the first save goes to slot 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary, the point at which acceptance is decided |
| pc_i | input | 16 | Address of the instruction at this boundary |
| flags_i | input | 4 | Current flag register; bit 3 is the interrupt enable |
| ei_done_i | input | 1 | The instruction that just finished set the enable flag |
| ext_done_i | input | 1 | The instruction that just finished loaded the extension register |
| swi_i | input | 1 | A software-interrupt instruction is decoded at this boundary |
| swi_addr_i | input | 6 | Vector field of the software interrupt |
| reti_i | input | 1 | A return-from-interrupt instruction is decoded at this boundary |
| nmi_req_i | input | 1 | Non-maskable request |
| irq_req_i | input | N_IRQ | Maskable requests |
| busy_o | output | 1 | A sequence is running, so the core stalls |
| nmi_ack_o | output | 1 | The non-maskable request was taken |
| irq_ack_o | output | N_IRQ | One-hot acknowledge of the maskable source that was taken |
| fetch_dummy_o | output | 1 | Dummy fetch cycle |
| sp1_we_o | output | 1 | Address-stack write |
| sp1_addr_o | output | 8 | Address-stack slot |
| sp1_wdata_o | output | 16 | Return address to save |
| sp1_rdata_i | input | 16 | Address-stack read data, combinational |
| sp2_we_o | output | 1 | Data-stack write |
| sp2_addr_o | output | 8 | Data-stack slot |
| sp2_wdata_o | output | 4 | Flags to save |
| sp2_rdata_i | input | 4 | Data-stack read data, combinational |
| flags_we_o | output | 1 | Flag register write |
| flags_wdata_o | output | 4 | Flag write value |
| pc_load_o | output | 1 | Program counter load |
| pc_next_o | output | 16 | Program counter load value |

## Verification
Acceptance is tried against several input patterns. One has the non-maskable request with the enable flag clear, and another has it together with maskable requests, which separates priority from masking. Another has several maskable requests, which shows that the lowest index is picked, and another has a maskable request while the enable flag is clear, which shows that masking holds. Boundaries marked by an enable-set instruction and by an extension load show that the block waits exactly one instruction and does not drop the request. Software interrupts and a pair of nested entries, each followed by its return, check the return-address offset, the vector arithmetic and the last-in, first-out order of both stacks.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_EDUMMY  = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_PUSH_F  = 3'd3,
    ST_VECTOR  = 3'd4,
    ST_RDUMMY  = 3'd5,
    ST_POP_F   = 3'd6,
    ST_POP_PC  = 3'd7
  } seq_state_t;

  localparam logic [15:0] SWI_BASE = 16'h0100;

  // Software interrupt target: fixed page plus the 6-bit field.
  function automatic logic [15:0] swi_vector(input logic [5:0] field);
    return SWI_BASE + {10'd0, field};
  endfunction

  // Return address saved by a software interrupt.
  function automatic logic [15:0] swi_return(input logic [15:0] pc);
    return pc + 16'd1;
  endfunction

  // Flags written in the vector cycle: enable bit forced low.
  function automatic logic [3:0] drop_enable(input logic [3:0] f, input int unsigned idx);
    logic [3:0] r;
    r = f;
    r[idx] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb #(
  parameter int unsigned N_IRQ          = 4,
  parameter logic [15:0] NMI_VEC        = 16'h0002,
  parameter logic [N_IRQ*16-1:0] HW_VEC = {16'h000C, 16'h000A, 16'h0008, 16'h0006}
) (
  input  logic              boundary_i,
  input  logic              idle_i,
  input  logic              ien_i,
  input  logic              ei_done_i,
  input  logic              ext_done_i,
  input  logic              nmi_req_i,
  input  logic [N_IRQ-1:0]  irq_req_i,
  output logic              take_hw_o,
  output logic              nmi_ack_o,
  output logic [N_IRQ-1:0]  irq_ack_o,
  output logic [15:0]       hw_vec_o
);

  logic [N_IRQ-1:0] grant;
  logic             any_req;
  logic             hw_window;
  logic             mask_open;
  logic             nmi_take;
  logic             irq_take;
  logic [15:0]      vec_tbl [N_IRQ];

  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_vec
      assign vec_tbl[g] = HW_VEC[g*16 +: 16];
    end
  endgenerate

  // Lowest active index wins.
  always_comb begin
    grant   = '0;
    any_req = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (irq_req_i[i] && !any_req) begin
        grant[i] = 1'b1;
        any_req  = 1'b1;
      end
    end
  end

  assign hw_window = boundary_i & idle_i & ~ext_done_i;
  assign mask_open = ien_i & ~ei_done_i;
  assign nmi_take  = hw_window & nmi_req_i;
  assign irq_take  = hw_window & mask_open & ~nmi_req_i & any_req;

  assign nmi_ack_o = nmi_take;
  assign irq_ack_o = irq_take ? grant : '0;
  assign take_hw_o = nmi_take | irq_take;

  always_comb begin
    hw_vec_o = NMI_VEC;
    if (!nmi_req_i) begin
      for (int i = 0; i < N_IRQ; i++) begin
        if (grant[i]) hw_vec_o = vec_tbl[i];
      end
    end
  end

endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
  parameter int unsigned    AW  = 8,
  parameter logic [AW-1:0]  RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_o <= RST;
    else if (dec_i) ptr_o <= ptr_o - ONE;
    else if (inc_i) ptr_o <= ptr_o + ONE;
  end

endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
  import irq_seq_pkg::*;
#(
  parameter int unsigned SP1_AW = 8,
  parameter int unsigned SP2_AW = 8,
  parameter int unsigned I_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              take_hw_i,
  input  logic [15:0]       hw_vec_i,
  input  logic [15:0]       pc_i,
  input  logic [3:0]        flags_i,
  input  logic              swi_i,
  input  logic [5:0]        swi_addr_i,
  input  logic              reti_i,
  input  logic [SP1_AW-1:0] sp1_ptr_i,
  input  logic [SP2_AW-1:0] sp2_ptr_i,
  input  logic [15:0]       sp1_rdata_i,
  input  logic [3:0]        sp2_rdata_i,
  output logic              idle_o,
  output logic              fetch_dummy_o,
  output logic              sp1_we_o,
  output logic              sp1_dec_o,
  output logic              sp1_inc_o,
  output logic [SP1_AW-1:0] sp1_addr_o,
  output logic [15:0]       sp1_wdata_o,
  output logic              sp2_we_o,
  output logic              sp2_dec_o,
  output logic              sp2_inc_o,
  output logic [SP2_AW-1:0] sp2_addr_o,
  output logic [3:0]        sp2_wdata_o,
  output logic              flags_we_o,
  output logic [3:0]        flags_wdata_o,
  output logic              pc_load_o,
  output logic [15:0]       pc_next_o
);

  seq_state_t state_q, state_d;
  logic [15:0] ret_q;
  logic [15:0] vec_q;
  logic [3:0]  fsav_q;
  logic        start_entry;
  logic        start_swi;
  logic        start_ret;

  assign idle_o      = (state_q == ST_IDLE);
  assign start_entry = idle_o & take_hw_i;
  assign start_swi   = idle_o & boundary_i & ~take_hw_i & swi_i;
  assign start_ret   = idle_o & boundary_i & ~take_hw_i & ~swi_i & reti_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_entry || start_swi) state_d = ST_EDUMMY;
        else if (start_ret)           state_d = ST_RDUMMY;
      end
      ST_EDUMMY:  state_d = ST_PUSH_PC;
      ST_PUSH_PC: state_d = ST_PUSH_F;
      ST_PUSH_F:  state_d = ST_VECTOR;
      ST_VECTOR:  state_d = ST_IDLE;
      ST_RDUMMY:  state_d = ST_POP_F;
      ST_POP_F:   state_d = ST_POP_PC;
      ST_POP_PC:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= '0;
      vec_q   <= '0;
      fsav_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_entry) begin
        ret_q  <= pc_i;
        vec_q  <= hw_vec_i;
        fsav_q <= flags_i;
      end else if (start_swi) begin
        ret_q  <= swi_return(pc_i);
        vec_q  <= swi_vector(swi_addr_i);
        fsav_q <= flags_i;
      end
    end
  end

  always_comb begin
    fetch_dummy_o = (state_q == ST_EDUMMY) || (state_q == ST_RDUMMY);
    sp1_we_o      = (state_q == ST_PUSH_PC);
    sp1_dec_o     = sp1_we_o;
    sp1_inc_o     = (state_q == ST_POP_PC);
    sp1_addr_o    = sp1_we_o ? (sp1_ptr_i - SP1_AW'(1)) : sp1_ptr_i;
    sp1_wdata_o   = ret_q;
    sp2_we_o      = (state_q == ST_PUSH_F);
    sp2_dec_o     = sp2_we_o;
    sp2_inc_o     = (state_q == ST_POP_F);
    sp2_addr_o    = sp2_we_o ? (sp2_ptr_i - SP2_AW'(1)) : sp2_ptr_i;
    sp2_wdata_o   = fsav_q;
    flags_we_o    = 1'b0;
    flags_wdata_o = '0;
    pc_load_o     = 1'b0;
    pc_next_o     = '0;
    if (state_q == ST_VECTOR) begin
      flags_we_o    = 1'b1;
      flags_wdata_o = drop_enable(fsav_q, I_BIT);
      pc_load_o     = 1'b1;
      pc_next_o     = vec_q;
    end else if (state_q == ST_POP_F) begin
      flags_we_o    = 1'b1;
      flags_wdata_o = sp2_rdata_i;
    end else if (state_q == ST_POP_PC) begin
      pc_load_o     = 1'b1;
      pc_next_o     = sp1_rdata_i;
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned          N_IRQ   = 4,
  parameter int unsigned          SP1_AW  = 8,
  parameter int unsigned          SP2_AW  = 8,
  parameter int unsigned          I_BIT   = 3,
  parameter logic [SP1_AW-1:0]    SP1_RST = '0,
  parameter logic [SP2_AW-1:0]    SP2_RST = '0,
  parameter logic [15:0]          NMI_VEC = 16'h0002,
  parameter logic [N_IRQ*16-1:0]  HW_VEC  = {16'h000C, 16'h000A, 16'h0008, 16'h0006}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic [15:0]       pc_i,
  input  logic [3:0]        flags_i,
  input  logic              ei_done_i,
  input  logic              ext_done_i,
  input  logic              swi_i,
  input  logic [5:0]        swi_addr_i,
  input  logic              reti_i,
  input  logic              nmi_req_i,
  input  logic [N_IRQ-1:0]  irq_req_i,
  output logic              busy_o,
  output logic              nmi_ack_o,
  output logic [N_IRQ-1:0]  irq_ack_o,
  output logic              fetch_dummy_o,
  output logic              sp1_we_o,
  output logic [SP1_AW-1:0] sp1_addr_o,
  output logic [15:0]       sp1_wdata_o,
  input  logic [15:0]       sp1_rdata_i,
  output logic              sp2_we_o,
  output logic [SP2_AW-1:0] sp2_addr_o,
  output logic [3:0]        sp2_wdata_o,
  input  logic [3:0]        sp2_rdata_i,
  output logic              flags_we_o,
  output logic [3:0]        flags_wdata_o,
  output logic              pc_load_o,
  output logic [15:0]       pc_next_o
);

  logic              idle;
  logic              take_hw;
  logic [15:0]       hw_vec;
  logic [SP1_AW-1:0] sp1_ptr;
  logic [SP2_AW-1:0] sp2_ptr;
  logic              sp1_dec, sp1_inc, sp2_dec, sp2_inc;

  assign busy_o = ~idle;

  irq_seq_arb #(
    .N_IRQ   (N_IRQ),
    .NMI_VEC (NMI_VEC),
    .HW_VEC  (HW_VEC)
  ) arb_i (
    .boundary_i (boundary_i),
    .idle_i     (idle),
    .ien_i      (flags_i[I_BIT]),
    .ei_done_i  (ei_done_i),
    .ext_done_i (ext_done_i),
    .nmi_req_i  (nmi_req_i),
    .irq_req_i  (irq_req_i),
    .take_hw_o  (take_hw),
    .nmi_ack_o  (nmi_ack_o),
    .irq_ack_o  (irq_ack_o),
    .hw_vec_o   (hw_vec)
  );

  irq_seq_sp #(.AW(SP1_AW), .RST(SP1_RST)) sp1_i (
    .clk (clk), .rst_n (rst_n), .dec_i (sp1_dec), .inc_i (sp1_inc), .ptr_o (sp1_ptr)
  );

  irq_seq_sp #(.AW(SP2_AW), .RST(SP2_RST)) sp2_i (
    .clk (clk), .rst_n (rst_n), .dec_i (sp2_dec), .inc_i (sp2_inc), .ptr_o (sp2_ptr)
  );

  irq_seq_ctl #(
    .SP1_AW (SP1_AW),
    .SP2_AW (SP2_AW),
    .I_BIT  (I_BIT)
  ) ctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .boundary_i    (boundary_i),
    .take_hw_i     (take_hw),
    .hw_vec_i      (hw_vec),
    .pc_i          (pc_i),
    .flags_i       (flags_i),
    .swi_i         (swi_i),
    .swi_addr_i    (swi_addr_i),
    .reti_i        (reti_i),
    .sp1_ptr_i     (sp1_ptr),
    .sp2_ptr_i     (sp2_ptr),
    .sp1_rdata_i   (sp1_rdata_i),
    .sp2_rdata_i   (sp2_rdata_i),
    .idle_o        (idle),
    .fetch_dummy_o (fetch_dummy_o),
    .sp1_we_o      (sp1_we_o),
    .sp1_dec_o     (sp1_dec),
    .sp1_inc_o     (sp1_inc),
    .sp1_addr_o    (sp1_addr_o),
    .sp1_wdata_o   (sp1_wdata_o),
    .sp2_we_o      (sp2_we_o),
    .sp2_dec_o     (sp2_dec),
    .sp2_inc_o     (sp2_inc),
    .sp2_addr_o    (sp2_addr_o),
    .sp2_wdata_o   (sp2_wdata_o),
    .flags_we_o    (flags_we_o),
    .flags_wdata_o (flags_wdata_o),
    .pc_load_o     (pc_load_o),
    .pc_next_o     (pc_next_o)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned N_IRQ  = 4,
  parameter int unsigned SP1_AW = 8,
  parameter int unsigned SP2_AW = 8,
  parameter int unsigned I_BIT  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        flags_i,
  input logic              ei_done_i,
  input logic              ext_done_i,
  input logic              nmi_ack_o,
  input logic [N_IRQ-1:0]  irq_ack_o,
  input logic              busy_o,
  input logic              fetch_dummy_o,
  input logic              sp1_we_o,
  input logic [SP1_AW-1:0] sp1_addr_o,
  input logic              sp2_we_o,
  input logic [SP2_AW-1:0] sp2_addr_o,
  input logic              flags_we_o,
  input logic [3:0]        flags_wdata_o,
  input logic              pc_load_o,
  input logic [SP1_AW-1:0] sp1_ptr,
  input logic [SP2_AW-1:0] sp2_ptr
);

  AST_NMI_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack_o |-> (irq_ack_o == '0)); // R1
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_ack_o, irq_ack_o})); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |-> flags_i[I_BIT]); // R2
  AST_EI_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ei_done_i |-> (irq_ack_o == '0)); // R3
  AST_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_done_i |-> (!nmi_ack_o && irq_ack_o == '0)); // R4
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!nmi_ack_o && irq_ack_o == '0)); // R5
  AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack_o || (|irq_ack_o)) |=> fetch_dummy_o); // R5
  AST_PC_THEN_F: assert property (@(posedge clk) disable iff (!rst_n)
    sp1_we_o |=> sp2_we_o); // R5
  AST_SP1_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sp1_we_o |=> (sp1_ptr == $past(sp1_addr_o))); // R5
  AST_SP2_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sp2_we_o |=> (sp2_ptr == $past(sp2_addr_o))); // R5
  AST_VEC_CLEARS_I: assert property (@(posedge clk) disable iff (!rst_n)
    sp2_we_o |=> (pc_load_o && flags_we_o && !flags_wdata_o[I_BIT])); // R8

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .N_IRQ (N_IRQ), .SP1_AW (SP1_AW), .SP2_AW (SP2_AW), .I_BIT (I_BIT)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .flags_i       (flags_i),
  .ei_done_i     (ei_done_i),
  .ext_done_i    (ext_done_i),
  .nmi_ack_o     (nmi_ack_o),
  .irq_ack_o     (irq_ack_o),
  .busy_o        (busy_o),
  .fetch_dummy_o (fetch_dummy_o),
  .sp1_we_o      (sp1_we_o),
  .sp1_addr_o    (sp1_addr_o),
  .sp2_we_o      (sp2_we_o),
  .sp2_addr_o    (sp2_addr_o),
  .flags_we_o    (flags_we_o),
  .flags_wdata_o (flags_wdata_o),
  .pc_load_o     (pc_load_o),
  .sp1_ptr       (sp1_ptr),
  .sp2_ptr       (sp2_ptr)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  typedef enum int {EV_ACK, EV_DUMMY, EV_SP1W, EV_SP2W, EV_FLAGW, EV_PCLD} ev_t;
  typedef struct {
    ev_t         kind;
    logic [15:0] addr;
    logic [15:0] data;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0;
  logic [15:0] pc = '0;
  logic [3:0] flags = '0;
  logic ei = 1'b0, ext = 1'b0, swi = 1'b0, reti = 1'b0;
  logic [5:0] swi_addr = '0;
  logic nmi = 1'b0;
  logic [N-1:0] irq = '0;

  logic busy, nmi_ack, dmy, sp1_we, sp2_we, fwe, pcl;
  logic [N-1:0] irq_ack;
  logic [7:0] sp1_addr, sp2_addr;
  logic [15:0] sp1_wd, sp1_rd, pc_nx;
  logic [3:0] sp2_wd, sp2_rd, fwd;

  logic [15:0] m1 [256];
  logic [3:0]  m2 [256];

  int tests = 0;
  int fails = 0;
  item_t exp_q[$];
  logic [7:0] b_sp1 = 8'h00, b_sp2 = 8'h00;
  logic [19:0] shadow[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq dut_i (
    .clk (clk), .rst_n (rst_n), .boundary_i (boundary), .pc_i (pc), .flags_i (flags),
    .ei_done_i (ei), .ext_done_i (ext), .swi_i (swi), .swi_addr_i (swi_addr), .reti_i (reti),
    .nmi_req_i (nmi), .irq_req_i (irq), .busy_o (busy), .nmi_ack_o (nmi_ack),
    .irq_ack_o (irq_ack), .fetch_dummy_o (dmy), .sp1_we_o (sp1_we), .sp1_addr_o (sp1_addr),
    .sp1_wdata_o (sp1_wd), .sp1_rdata_i (sp1_rd), .sp2_we_o (sp2_we), .sp2_addr_o (sp2_addr),
    .sp2_wdata_o (sp2_wd), .sp2_rdata_i (sp2_rd), .flags_we_o (fwe), .flags_wdata_o (fwd),
    .pc_load_o (pcl), .pc_next_o (pc_nx)
  );

  // Stack RAMs with combinational read.
  always @(posedge clk) begin
    if (sp1_we) m1[sp1_addr] <= sp1_wd;
    if (sp2_we) m2[sp2_addr] <= sp2_wd;
  end
  assign sp1_rd = m1[sp1_addr];
  assign sp2_rd = m2[sp2_addr];

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic exp_push(input ev_t k, input logic [15:0] a, input logic [15:0] d, input string r);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic observe(input ev_t k, input logic [15:0] a, input logic [15:0] d);
    item_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R5/R9", $sformatf("unexpected event %0d", k), {a, d}, 32'h0);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k && e.addr == a && e.data == d, e.req,
            $sformatf("event kind %0d/%0d", k, e.kind), {a, d}, {e.addr, e.data});
    end
  endtask

  // Monitor: sample each cycle away from the edge, pop and compare.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (nmi_ack || (|irq_ack)) observe(EV_ACK, 16'h0, {11'd0, nmi_ack, irq_ack});
        if (dmy)    observe(EV_DUMMY, 16'h0, 16'h0);
        if (sp1_we) observe(EV_SP1W, {8'h0, sp1_addr}, sp1_wd);
        if (sp2_we) observe(EV_SP2W, {8'h0, sp2_addr}, {12'h0, sp2_wd});
        if (fwe)    observe(EV_FLAGW, 16'h0, {12'h0, fwd});
        if (pcl)    observe(EV_PCLD, 16'h0, pc_nx);
      end
    end
  end

  // Driver: predict from the requirements, then present one boundary.
  task automatic step(input logic s_ei, input logic s_ext, input logic s_swi,
                      input logic [5:0] s_sa, input logic s_reti, input logic [15:0] s_pc,
                      input string tag);
    logic hw, found;
    logic [N-1:0] g;
    logic [15:0] vec, ret;
    logic [19:0] sh;
    hw = 1'b0; g = '0; found = 1'b0; vec = '0; ret = s_pc;
    for (int i = 0; i < N; i++) if (irq[i] && !found) begin g[i] = 1'b1; found = 1'b1; end
    if (!s_ext && nmi) begin
      hw = 1'b1; g = '0; vec = 16'h0002;                     // R1
    end else if (!s_ext && flags[3] && !s_ei && found) begin
      hw = 1'b1;
      for (int i = 0; i < N; i++) if (g[i]) vec = 16'h0006 + 16'(2*i);  // R7
    end
    if (hw || s_swi) begin
      if (!hw) begin ret = s_pc + 16'd1; vec = 16'h0100 + {10'd0, s_sa}; end
      if (hw) exp_push(EV_ACK, 16'h0, {11'd0, nmi && !s_ext, g}, "R1/R2");
      exp_push(EV_DUMMY, 16'h0, 16'h0, "R5");
      exp_push(EV_SP1W, {8'h0, b_sp1 - 8'd1}, ret, "R5/R6");
      exp_push(EV_SP2W, {8'h0, b_sp2 - 8'd1}, {12'h0, flags}, "R8");
      exp_push(EV_FLAGW, 16'h0, {12'h0, flags & 4'b0111}, "R8");
      exp_push(EV_PCLD, 16'h0, vec, hw ? "R7" : "R7 swi");
      b_sp1 = b_sp1 - 8'd1; b_sp2 = b_sp2 - 8'd1;
      shadow.push_back({flags, ret});
    end else if (s_reti) begin
      sh = shadow.pop_back();
      exp_push(EV_DUMMY, 16'h0, 16'h0, "R9");
      exp_push(EV_FLAGW, 16'h0, {12'h0, sh[19:16]}, "R9");
      exp_push(EV_PCLD, 16'h0, sh[15:0], "R9");
      b_sp1 = b_sp1 + 8'd1; b_sp2 = b_sp2 + 8'd1;
    end
    @(posedge clk); #1;
    boundary = 1'b1; ei = s_ei; ext = s_ext; swi = s_swi; swi_addr = s_sa; reti = s_reti; pc = s_pc;
    @(posedge clk); #1;
    boundary = 1'b0; ei = 1'b0; ext = 1'b0; swi = 1'b0; reti = 1'b0;
    if (hw) begin nmi = 1'b0; irq = irq & ~g; end
    repeat (6) @(posedge clk);
    #1;
    check(exp_q.size() == 0 && !busy, tag, "sequence drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(!busy && !sp1_we && !sp2_we && !pcl && !fwe && !nmi_ack && irq_ack == '0,
          "R10", "idle after reset", {busy, sp1_we, sp2_we, pcl}, 0);
    rst_n = 1'b1;

    // R1: NMI with enable clear
    flags = 4'b0101; nmi = 1'b1;
    step(0, 0, 0, 0, 0, 16'h0200, "R1");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");

    // R2: several maskable, lowest wins
    flags = 4'b1010; irq = 4'b0110;
    step(0, 0, 0, 0, 0, 16'h0310, "R2");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");
    irq = '0;

    // R1: NMI beats maskable
    flags = 4'b1001; nmi = 1'b1; irq = 4'b0001;
    step(0, 0, 0, 0, 0, 16'h0420, "R1");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");
    irq = '0;

    // R2: masked while enable clear
    flags = 4'b0011; irq = 4'b1000;
    step(0, 0, 0, 0, 0, 16'h0500, "R2 masked");
    flags = 4'b1011;
    step(0, 0, 0, 0, 0, 16'h0501, "R2");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");

    // R3: enable-set instruction delays by one
    flags = 4'b1000; irq = 4'b0100;
    step(1, 0, 0, 0, 0, 16'h0600, "R3 held");
    step(0, 0, 0, 0, 0, 16'h0601, "R3");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");

    // R4: extension load delays even NMI
    flags = 4'b0000; nmi = 1'b1;
    step(0, 1, 0, 0, 0, 16'h0700, "R4 held");
    step(0, 0, 0, 0, 0, 16'h0701, "R4");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");

    // R6/R7: software interrupt
    flags = 4'b1110;
    step(0, 0, 1, 6'h2A, 0, 16'h1234, "R6");
    step(0, 0, 0, 0, 1, 16'h0000, "R9");
    step(0, 0, 1, 6'h3F, 0, 16'hFFFF, "R7");

    // Nested entries, then LIFO returns
    flags = 4'b1000; irq = 4'b1000;
    step(0, 0, 0, 0, 0, 16'h0800, "R5 nested");
    step(0, 0, 0, 0, 1, 16'h0000, "R9 nested");
    step(0, 0, 0, 0, 1, 16'h0000, "R9 nested");
    irq = '0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule